// File: doc/BRIEF.md
# Single-Digit Decimal/Hex Digit Multiplier

This block multiplies two 4-bit digit operands in pure combinational logic and returns an 8-bit result in the same cycle. A mode input chooses how that result is formed. In decimal mode the operands are treated as decimal digits and the product is returned as two packed decimal digits. In hex mode the operands are plain nibbles and the product is the unsigned binary value.

In decimal mode an operand above nine is rejected. A flag is raised and the result is held at zero. The block is meant to be placed as the partial-product generator inside wider decimal multipliers. It stores nothing and keeps no table of multiples.

Top module: `digit_mul_top`

## Requirements
- R1: With `hex_mode`=0 and both operands in 0..9, `product` equals {tens, units} of op_a×op_b, where bits 7:4 hold the tens digit and bits 3:0 hold the units digit. For example, 7×8 gives 8'h56 and 9×9 gives 8'h81.
- R2: With `hex_mode`=0, `product[7:4]` never exceeds 8 and `product[3:0]` never exceeds 9. Decimal results stay within 0..81.
- R3: With `hex_mode`=1, `product` equals the unsigned binary product op_a×op_b for any operands 0..15. For example, 15×15 gives 8'hE1.
- R4: With `hex_mode`=0 and either operand in 10..15, `bad_digit` is 1 and `product` is 8'h00.
- R5: With `hex_mode`=1, `bad_digit` is 0 for every operand pair.
- R6: With `hex_mode`=0 and both operands in 0..9, `bad_digit` is 0.
- R7: `product` and `bad_digit` depend only on the present inputs. They are valid in the same cycle the inputs change, with no state carried between operand pairs.
- R8: A zero operand gives `product` 8'h00 in both modes whenever the other operand is acceptable in that mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hex_mode | input | 1 | 1 selects the binary product, 0 selects the packed decimal product |
| op_a | input | 4 | First digit operand |
| op_b | input | 4 | Second digit operand |
| product | output | 8 | Packed decimal digits {tens, units}, or the binary product |
| bad_digit | output | 1 | Decimal mode only: an operand lies above nine |

## Verification
Both results come from combinational logic, so they are due zero cycles after the inputs change. The bench applies each operand pair just after a rising clock edge and compares both outputs at the following falling edge, within the same cycle. The pairs are swept exhaustively in both modes, one pair per clock. Successive pairs differ, so any result held over from a previous pair would be seen at once.

// File: rtl/digit_mul_pkg.sv
package digit_mul_pkg;
  localparam int DIGIT_W   = 4;
  localparam int PROD_W    = 2 * DIGIT_W;
  localparam int BCD_DIGS  = 3;
  localparam int BCD_W     = 4 * BCD_DIGS;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [PROD_W-1:0]  prod_t;

  localparam digit_t MAX_DEC_DIGIT = digit_t'(9);

  typedef enum logic {
    MODE_DEC = 1'b0,
    MODE_HEX = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/digit_range_check.sv
module digit_range_check
  import digit_mul_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic [W-1:0] dig_a,
  input  logic [W-1:0] dig_b,
  output logic         both_ok
);
  localparam logic [W-1:0] LIMIT = W'(MAX_DEC_DIGIT);

  logic ok_a;
  logic ok_b;

  always_comb begin
    ok_a    = (dig_a <= LIMIT);
    ok_b    = (dig_b <= LIMIT);
    both_ok = ok_a & ok_b;
  end
endmodule

// File: rtl/nibble_mul.sv
module nibble_mul #(
  parameter int W = 4
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] bin_prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pp [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pp
      assign pp[gi] = mplier[gi] ? (PW'(mcand) << gi) : '0;
    end
  endgenerate

  always_comb begin
    bin_prod = '0;
    for (int k = 0; k < W; k++) begin
      bin_prod = bin_prod + pp[k];
    end
  end
endmodule

// File: rtl/bin_to_dec.sv
module bin_to_dec #(
  parameter int IN_W  = 8,
  parameter int NDIG  = 3
) (
  input  logic [IN_W-1:0]   bin_in,
  output logic [4*NDIG-1:0] dec_out
);
  localparam int OW = 4 * NDIG;

  logic [OW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (acc[4*d +: 4] >= 4'd5) begin
          acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
        end
      end
      acc = {acc[OW-2:0], bin_in[i]};
    end
    dec_out = acc;
  end
endmodule

// File: rtl/digit_mul_top.sv
module digit_mul_top
  import digit_mul_pkg::*;
(
  input  logic       hex_mode,
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  output logic [7:0] product,
  output logic       bad_digit
);
  logic          digits_ok;
  prod_t         raw_prod;
  logic [BCD_W-1:0] dec_full;
  prod_t         dec_packed;
  mul_mode_e     mode_sel;

  assign mode_sel = mul_mode_e'(hex_mode);

  digit_range_check #(.W(DIGIT_W)) u_range (
    .dig_a   (op_a),
    .dig_b   (op_b),
    .both_ok (digits_ok)
  );

  nibble_mul #(.W(DIGIT_W)) u_mul (
    .mcand    (op_a),
    .mplier   (op_b),
    .bin_prod (raw_prod)
  );

  bin_to_dec #(.IN_W(PROD_W), .NDIG(BCD_DIGS)) u_conv (
    .bin_in  (raw_prod),
    .dec_out (dec_full)
  );

  assign dec_packed = dec_full[PROD_W-1:0];

  always_comb begin
    product   = '0;
    bad_digit = 1'b0;
    unique case (mode_sel)
      MODE_HEX: begin
        product = raw_prod;
      end
      MODE_DEC: begin
        bad_digit = ~digits_ok;
        product   = digits_ok ? dec_packed : '0;
      end
      default: begin
        product = '0;
      end
    endcase
  end

  logic unused_hi;
  assign unused_hi = ^dec_full[BCD_W-1:PROD_W];
endmodule

// File: rtl/digit_mul_chk.sv
module digit_mul_chk (
  input logic       hex_mode,
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic [7:0] product,
  input logic       bad_digit
);
  int unsigned ref_p;
  logic        in_range;

  always_comb begin
    ref_p    = int'(op_a) * int'(op_b);
    in_range = (op_a <= 4'd9) && (op_b <= 4'd9);

    if (!hex_mode && in_range) begin
      a_r1_dec_value: assert (product == {4'(ref_p / 10), 4'(ref_p % 10)});
      a_r6_dec_noflag: assert (!bad_digit);
    end
    if (!hex_mode) begin
      a_r2_dec_range: assert (product[7:4] <= 4'd8 && product[3:0] <= 4'd9);
    end
    if (hex_mode) begin
      a_r3_hex_value: assert (product == 8'(ref_p));
      a_r5_hex_noflag: assert (!bad_digit);
    end
    if (!hex_mode && !in_range) begin
      a_r4_bad_zero: assert (bad_digit && product == 8'h00);
    end
  end
endmodule

bind digit_mul_top digit_mul_chk u_chk (
  .hex_mode  (hex_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .product   (product),
  .bad_digit (bad_digit)
);

// File: tb/tb_digit_mul_top.sv
module tb_digit_mul_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       hex_mode;
  logic [3:0] op_a;
  logic [3:0] op_b;
  logic [7:0] product;
  logic       bad_digit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  digit_mul_top dut (
    .hex_mode  (hex_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .product   (product),
    .bad_digit (bad_digit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (mode=%0d a=%0d b=%0d)",
               req, act, exp, hex_mode, op_a, op_b);
    end
  endtask

  // Reference: behavioural model from the requirements.
  task automatic apply_and_check(input bit m, input int a, input int b);
    int p;
    int exp_prod;
    int exp_flag;
    @(posedge clk);
    hex_mode = m;
    op_a     = 4'(a);
    op_b     = 4'(b);
    @(negedge clk);
    p = a * b;
    if (m) begin
      exp_prod = p;
      exp_flag = 0;
      check("R3 hex product", int'(product), exp_prod);
      check("R5 hex flag", int'(bad_digit), exp_flag);
    end else if (a > 9 || b > 9) begin
      check("R4 bad digit flag", int'(bad_digit), 1);
      check("R4 forced zero", int'(product), 0);
    end else begin
      exp_prod = ((p / 10) << 4) | (p % 10);
      check("R1 decimal product", int'(product), exp_prod);
      check("R6 decimal flag", int'(bad_digit), 0);
      total++;
      if (product[7:4] > 4'd8 || product[3:0] > 4'd9) begin
        bad++;
        $display("FAIL R2 digit range: actual=%0h expected<=81", product);
      end
    end
    if ((a == 0 || b == 0) && (m || (a <= 9 && b <= 9)))
      check("R8 zero operand", int'(product), 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    hex_mode = 1'b0;
    op_a     = 4'd0;
    op_b     = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset-time zero product", int'(product), 0);
    check("R6 reset-time flag", int'(bad_digit), 0);
    rst_n = 1'b1;

    // Named corners
    apply_and_check(1'b0, 7, 8);   // R1: 8'h56
    apply_and_check(1'b0, 9, 9);   // R1/R2: 8'h81
    apply_and_check(1'b1, 15, 15); // R3: 8'hE1
    apply_and_check(1'b0, 10, 3);  // R4
    apply_and_check(1'b0, 2, 15);  // R4
    apply_and_check(1'b1, 12, 0);  // R8

    // R7: alternate modes on the same pair, output must follow at once
    apply_and_check(1'b1, 9, 9);
    apply_and_check(1'b0, 9, 9);
    apply_and_check(1'b1, 11, 7);
    apply_and_check(1'b0, 11, 7);

    // Exhaustive sweep, both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          apply_and_check(m[0], a, b);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule